// File: doc/BRIEF.md
# USB Transmit Serializer

This block sits between a link controller and the line driver of a USB port. The link presents a byte on a parallel bus together with a valid flag. The block answers with a one-cycle accept strobe (`txNxt`). The first byte of a packet is a transmit command. The bytes after it are payload, and a stop flag comes with the last one. The block produces one line state per clock: J, K or SE0. An output-enable flag marks the cycles that belong to a packet.

A command whose low nibble is nonzero carries a PID. For such a command the block sends a SYNC pattern and then builds the PID byte from that nibble. The payload follows, and an end-of-packet sequence closes the frame. A command whose low nibble is zero sends its payload raw, with no SYNC and no end-of-packet. All bits go out least significant bit first. They are bit-stuffed and then NRZI-encoded.

While a byte is still being shifted out, `txNxt` stays low, so the link keeps its current byte on the bus. The next byte is taken in the same cycle that the last bit of the current byte leaves, so the bit stream has no gaps.

Top module: `usb_tx_serializer`

## Requirements
- R1: After reset and between packets, `lineState` is J (2'b01) with `lineOe` low, and `txNxt` is low while `txValid` is low. The line codes are SE0 = 2'b00, J = 2'b01 and K = 2'b10.
- R2: When idle, a byte is accepted as a command only if bits [7:6] are 2'b01. Any other byte is never acknowledged on `txNxt` and leaves the line idle.
- R3: For a command with a nonzero low nibble `p`, the wire bits start with seven 0 bits and one 1 bit (SYNC). The byte {~p, p} follows, sent low bit first.
- R4: Payload bytes are sent low bit first, one bit per clock, in the order they were accepted. There are no idle cycles between bytes.
- R5: After six consecutive 1 bits, a 0 bit is inserted. This also applies when the sixth 1 is the last bit of the packet.
- R6: NRZI: a 0 bit (stuffed bits included) flips the line between J and K, and a 1 bit holds the line. Each packet starts from J.
- R7: A PID packet ends with two cycles of SE0 and then one cycle of J, all with `lineOe` high. After that, `lineOe` goes low.
- R8: A command with low nibble 0 sends only its stuffed, NRZI-coded payload, with no SYNC and no SE0. `lineOe` falls in the cycle after the last bit.
- R9: `txNxt` is only high when `txValid` is high. While a packet is being sent, payload bytes are accepted no more often than once every 8 clocks. The byte that carries the stop flag is the last one accepted.
- R10: A PID command that carries the stop flag produces SYNC, the PID byte and end-of-packet, with no payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| txData | input | 8 | Command or payload byte from the link |
| txValid | input | 1 | `txData` holds a byte to send |
| txStop | input | 1 | The current byte is the last of the packet |
| txNxt | output | 1 | The byte on `txData` is taken at this clock edge |
| lineState | output | 2 | Line state: SE0 2'b00, J 2'b01, K 2'b10 |
| lineOe | output | 1 | `lineState` belongs to a packet |

## Verification
A wrong ones-run count or a wrong NRZI level shows up on `lineState` within a byte time. From that bit on, every level after it is inverted or shifted, so a bit-by-bit comparison of the whole wire stream fails at the first bad bit. A wrong bit counter or a wrong last-byte flag shows up as `txNxt` pulsing in the middle of a byte. It can also show up as a missing or early end-of-packet, which the scoreboard reports as an extra bit or an unused expected bit when the packet finishes.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10
  } line_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;   // latch PID nibble from the command byte
    logic loadSync;  // load SYNC pattern into shifter
    logic loadPid;   // load PID byte built from latched nibble
    logic loadLink;  // load link byte into shifter
    logic emitBit;   // put one bit on the line (stuff or data)
    logic driveSe0;  // force SE0
    logic driveJ;    // force J and clear coder state
    logic oeNext;    // line output belongs to a packet
  } txStrobe_t;
endpackage

// File: rtl/usb_tx_datapath.sv
module usb_tx_datapath
  import usb_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [BYTE_W-1:0] linkByte,
  output logic              lastBit,
  output logic              emptyShift,
  output logic              stuffDue,
  output logic [1:0]        lineState,
  output logic              lineOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam int NIB_W = BYTE_W / 2;

  logic [BYTE_W-1:0] shReg;
  logic [CNT_W-1:0]  bitsLeft;
  logic [RUN_W-1:0]  onesRun;
  logic [NIB_W-1:0]  pidNib;
  logic              bitVal;
  logic [1:0]        lineNext;

  assign lastBit    = (bitsLeft == CNT_W'(1));
  assign emptyShift = (bitsLeft == '0);
  assign stuffDue   = (onesRun == RUN_W'(STUFF_RUN));
  assign bitVal     = stuffDue ? 1'b0 : shReg[0];

  always_comb begin
    lineNext = lineState;
    if (strobe.driveSe0)     lineNext = LINE_SE0;
    else if (strobe.driveJ)  lineNext = LINE_J;
    else if (strobe.emitBit) lineNext = bitVal ? lineState
                                       : ((lineState == LINE_J) ? LINE_K : LINE_J);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      bitsLeft  <= '0;
      onesRun   <= '0;
      pidNib    <= '0;
      lineState <= LINE_J;
      lineOe    <= 1'b0;
    end else begin
      lineState <= lineNext;
      lineOe    <= strobe.oeNext;
      if (strobe.loadCmd) pidNib <= linkByte[NIB_W-1:0];
      if (strobe.driveJ) onesRun <= '0;
      else if (strobe.emitBit) onesRun <= bitVal ? onesRun + RUN_W'(1) : '0;
      if (strobe.loadSync) begin
        shReg    <= {1'b1, {(BYTE_W-1){1'b0}}};
        bitsLeft <= CNT_W'(BYTE_W);
      end else if (strobe.loadPid) begin
        shReg    <= {~pidNib, pidNib};
        bitsLeft <= CNT_W'(BYTE_W);
      end else if (strobe.loadLink) begin
        shReg    <= linkByte;
        bitsLeft <= CNT_W'(BYTE_W);
      end else if (strobe.emitBit && !stuffDue && !emptyShift) begin
        shReg    <= shReg >> 1;
        bitsLeft <= bitsLeft - CNT_W'(1);
      end
    end
  end

  // R5: the ones run never passes the stuffing threshold
  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    onesRun <= RUN_W'(STUFF_RUN));
  // R6: a zero bit moves the line to the other level
  p_nrzi_flip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emitBit && !bitVal && !strobe.driveSe0 && !strobe.driveJ)
      |=> (lineState != $past(lineState)));
  // R1: an undriven line rests at J
  p_idle_j_r1: assert property (@(posedge clk) disable iff (!rstN)
    !lineOe |-> (lineState == LINE_J));
  // R7: SE0 never lasts a single cycle
  p_se0_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lineState == LINE_SE0 && $past(lineState) != LINE_SE0) |=> (lineState == LINE_SE0));
endmodule

// File: rtl/usb_tx_control.sv
module usb_tx_control
  import usb_tx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  input  logic              txStop,
  input  logic              lastBit,
  input  logic              emptyShift,
  input  logic              stuffDue,
  output logic              txNxt,
  output txStrobe_t         strobe
);
  localparam int NIB_W = BYTE_W / 2;

  typedef enum logic [2:0] {S_IDLE, S_WAITD, S_SEND, S_EOP1, S_EOPJ} state_t;

  state_t state, stateN;
  logic hasPid, hasPidN, pidPending, pidPendingN, lastAfterPid, lastAfterPidN;
  logic curLast, curLastN;
  logic isTxCmd, pidNz;

  assign isTxCmd = (txData[BYTE_W-1 -: 2] == 2'b01);
  assign pidNz   = |txData[NIB_W-1:0];

  always_comb begin
    strobe        = '0;
    txNxt         = 1'b0;
    stateN        = state;
    hasPidN       = hasPid;
    pidPendingN   = pidPending;
    lastAfterPidN = lastAfterPid;
    curLastN      = curLast;
    unique case (state)
      S_IDLE: begin
        strobe.driveJ = 1'b1;
        txNxt = txValid && isTxCmd;
        if (txNxt) begin
          strobe.loadCmd = 1'b1;
          hasPidN = pidNz;
          if (pidNz) begin
            strobe.loadSync = 1'b1;
            pidPendingN     = 1'b1;
            lastAfterPidN   = txStop;
            curLastN        = 1'b0;
            stateN          = S_SEND;
          end else if (!txStop) begin
            stateN = S_WAITD;
          end
        end
      end
      S_WAITD: begin
        strobe.driveJ = 1'b1;
        txNxt = txValid;
        if (txNxt) begin
          strobe.loadLink = 1'b1;
          curLastN        = txStop;
          stateN          = S_SEND;
        end
      end
      S_SEND: begin
        if (emptyShift && !stuffDue) begin
          if (hasPid) begin
            strobe.driveSe0 = 1'b1;
            strobe.oeNext   = 1'b1;
            stateN          = S_EOP1;
          end else begin
            strobe.driveJ = 1'b1;
            stateN        = S_IDLE;
          end
        end else begin
          strobe.emitBit = 1'b1;
          strobe.oeNext  = 1'b1;
          if (lastBit && !stuffDue && !curLast) begin
            if (pidPending) begin
              strobe.loadPid = 1'b1;
              pidPendingN    = 1'b0;
              curLastN       = lastAfterPid;
            end else if (txValid) begin
              txNxt           = 1'b1;
              strobe.loadLink = 1'b1;
              curLastN        = txStop;
            end else begin
              curLastN = 1'b1;  // link ran dry: close the packet
            end
          end
        end
      end
      S_EOP1: begin
        strobe.driveSe0 = 1'b1;
        strobe.oeNext   = 1'b1;
        stateN          = S_EOPJ;
      end
      S_EOPJ: begin
        strobe.driveJ = 1'b1;
        strobe.oeNext = 1'b1;
        stateN        = S_IDLE;
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      hasPid       <= 1'b0;
      pidPending   <= 1'b0;
      lastAfterPid <= 1'b0;
      curLast      <= 1'b0;
    end else begin
      state        <= stateN;
      hasPid       <= hasPidN;
      pidPending   <= pidPendingN;
      lastAfterPid <= lastAfterPidN;
      curLast      <= curLastN;
    end
  end

  // R9: an accept strobe needs a byte on the bus
  p_nxt_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    txNxt |-> txValid);
  // R9: no byte is taken while the shifter still holds unsent bits
  p_busy_no_nxt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SEND && !lastBit) |-> !txNxt);
  // R9: nothing follows the stop byte
  p_stop_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SEND && curLast) |-> !txNxt);
endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
  import usb_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  input  logic              txStop,
  output logic              txNxt,
  output logic [1:0]        lineState,
  output logic              lineOe
);
  txStrobe_t strobe;
  logic lastBit, emptyShift, stuffDue;

  usb_tx_control #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .txData(txData), .txValid(txValid), .txStop(txStop),
    .lastBit(lastBit), .emptyShift(emptyShift), .stuffDue(stuffDue),
    .txNxt(txNxt), .strobe(strobe)
  );

  usb_tx_datapath #(.BYTE_W(BYTE_W), .STUFF_RUN(STUFF_RUN)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .linkByte(txData),
    .lastBit(lastBit), .emptyShift(emptyShift), .stuffDue(stuffDue),
    .lineState(lineState), .lineOe(lineOe)
  );
endmodule

// File: tb/usb_tx_serializer_tb.sv
module usb_tx_serializer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] txData = '0;
  logic txValid = 1'b0;
  logic txStop = 1'b0;
  logic txNxt, lineOe;
  logic [1:0] lineState;

  int nChecks = 0;
  int nFails = 0;
  logic [1:0] expQ[$];
  string tagQ[$];
  logic [1:0] mLvl;
  int mRun;
  logic [7:0] payload [4];
  int cycles = 0;

  always #5 clk = ~clk;

  usb_tx_serializer dut_i (
    .clk(clk), .rstN(rstN), .txData(txData), .txValid(txValid), .txStop(txStop),
    .txNxt(txNxt), .lineState(lineState), .lineOe(lineOe)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: push one wire bit, stuffing and NRZI from the requirements
  task automatic pushBit(input logic b, input string tag);
    if (!b) mLvl = (mLvl == 2'b01) ? 2'b10 : 2'b01;
    expQ.push_back(mLvl); tagQ.push_back(tag);
    mRun = b ? mRun + 1 : 0;
    if (mRun == 6) begin  // R5 stuffed zero
      mLvl = (mLvl == 2'b01) ? 2'b10 : 2'b01;
      expQ.push_back(mLvl); tagQ.push_back("R5");
      mRun = 0;
    end
  endtask

  task automatic pushByte(input logic [7:0] v, input string tag);
    for (int i = 0; i < 8; i++) pushBit(v[i], tag);
  endtask

  task automatic putByte(input logic [7:0] d, input logic stop, output int accCycle);
    logic acc;
    txData = d; txValid = 1'b1; txStop = stop;
    forever begin
      #4; acc = txNxt;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    accCycle = int'($time / 10);
    @(negedge clk);
  endtask

  task automatic sendPacket(input logic [7:0] cmd, input int n);
    int t, tPrev;
    logic [3:0] p;
    p = cmd[3:0];
    mLvl = 2'b01; mRun = 0;
    if (p != 0) begin
      pushByte(8'h80, "R3");
      pushByte({~p, p}, (n == 0) ? "R10" : "R3");
      for (int i = 0; i < n; i++) pushByte(payload[i], "R4 R6");
      expQ.push_back(2'b00); tagQ.push_back("R7");
      expQ.push_back(2'b00); tagQ.push_back("R7");
      expQ.push_back(2'b01); tagQ.push_back("R7");
    end else begin
      for (int i = 0; i < n; i++) pushByte(payload[i], "R8");
    end
    putByte(cmd, n == 0, t);
    for (int i = 0; i < n; i++) begin
      tPrev = t;
      putByte(payload[i], i == n - 1, t);
      if (i > 0) check((t - tPrev) >= 8, "R9 byte spacing", t - tPrev, 8);
    end
    txValid = 1'b0; txStop = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    check(lineOe == 1'b0, (p != 0) ? "R7 oe low after packet" : "R8 oe low after packet", lineOe, 0);
    check(lineState == 2'b01, "R1 idle J after packet", lineState, 1);
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && lineOe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7 R8 unexpected line bit", lineState, -1);
      end else begin
        logic [1:0] e;
        string tg;
        e = expQ.pop_front(); tg = tagQ.pop_front();
        check(lineState == e, tg, lineState, e);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(lineState == 2'b01, "R1 reset line J", lineState, 1);
    check(lineOe == 1'b0, "R1 reset oe low", lineOe, 0);
    check(txNxt == 1'b0, "R1 reset nxt low", txNxt, 0);

    // R2: bytes that are not transmit commands are never taken
    txData = 8'h83; txValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #4; check(txNxt == 1'b0, "R2 non-command ignored", txNxt, 0);
      @(negedge clk);
      check(lineOe == 1'b0, "R2 line idle", lineOe, 0);
    end
    txData = 8'hC5;
    for (int i = 0; i < 3; i++) begin
      #4; check(txNxt == 1'b0, "R2 non-command ignored", txNxt, 0);
      @(negedge clk);
      check(lineState == 2'b01, "R2 line J", lineState, 1);
    end
    txValid = 1'b0;
    @(negedge clk);

    // PID packet with stuffing inside and at the very end (R3 R4 R5 R6 R7)
    payload[0] = 8'h00; payload[1] = 8'hFF; payload[2] = 8'h5A; payload[3] = 8'hFC;
    sendPacket(8'h43, 4);
    // R10: handshake-only packet
    sendPacket(8'h4A, 0);
    // R8: raw packet without framing
    payload[0] = 8'hA5; payload[1] = 8'h7E;
    sendPacket(8'h40, 2);
    // R5: stuffing across byte borders
    payload[0] = 8'hFF; payload[1] = 8'hFF; payload[2] = 8'hFF;
    sendPacket(8'h45, 3);
    // R8: raw packet ending in a run of ones
    payload[0] = 8'hFC;
    sendPacket(8'h40, 1);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule